// File: doc/BRIEF.md
# Tapered-Code Result Encoder

This block packs an internal floating-point style result (sign, zero flag, signed exponent and the fraction bits of a mantissa whose leading one is implied) into a compact tapered code that is 2, 4 or 8 bits wide. The width is chosen per item. A value of at least 1 is written as a run of ones, one longer than the exponent, at the top of the magnitude field. A single zero follows as a delimiter. The remaining positions take as many leading fraction bits as still fit. Because the exponent is unary, a larger exponent leaves fewer fraction bits.

A value below 1 has no exponent run. It is written as a leading zero followed by a plain binary fraction. The all-ones magnitude is the top of the range, and any larger exponent clamps to it. All dropped bits are truncated, so a code never decodes to more than the input magnitude. In signed mode the top bit of the selected width carries the sign, and the magnitude field is one bit narrower.

The block sits just ahead of write-back in an inference datapath. Results are registered, and a valid flag follows each item with one cycle of latency.

Top module: `tapered_encoder`

## Requirements
- R1: When the zero flag is set, the code is all zeros for every width, sign and signedness.
- R2: For an exponent e >= 0 that is below the saturation point, the magnitude field of M bits reads from its top as e+1 ones, one 0 delimiter, then the leading M-e-2 fraction bits. Lower fraction bits are dropped.
- R3: For a negative exponent the magnitude is a 0 followed by floor(value * 2^(M-1)) in M-1 bits. A value too small for that resolution yields zero.
- R4: An exponent e >= M-1 yields the all-ones magnitude, which stands for 2^(M-1).
- R5: Rounding is toward zero: decoding the code gives the largest representable magnitude that does not exceed the input.
- R6: The precision select reads 00 as 2 bits, 01 as 4 bits, and 10 or 11 as 8 bits. The code is right-justified in the output bus and all bits above the selected width are zero.
- R7: With the signed flag set, the top bit of the selected width is the sign and M is the width minus one. The sign bit is forced to 0 when the magnitude is zero. With the flag clear, the sign input is ignored.
- R8: The valid output rises in the cycle after each accepted input. Its code appears in that same cycle, and the valid output is low after an idle cycle.
- R9: The code output holds its last value while the input valid is low.
- R10: A synchronous active-high reset clears the valid output and the code.
- R11: Decoding each of the 16 unsigned 4-bit codes to exponent and fraction and then encoding the result gives back the same code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input item present |
| in_sign | input | 1 | Sign of the value (1 = negative) |
| in_zero | input | 1 | Value is exactly zero |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_frac | input | FRAC_W | Fraction bits below the implied leading one |
| in_prec | input | 2 | Width select: 00 = 2, 01 = 4, 1x = 8 bits |
| in_signed | input | 1 | Signed code format select |
| out_valid | output | 1 | Registered code valid |
| out_code | output | CODE_W | Packed code, right-justified |

## Verification
A reference model decodes every candidate code of the selected width and picks the largest one that does not exceed the input value. This separates correct truncation from off-by-one run lengths and misplaced delimiters. Directed items cover several cases: exponent 0 with fraction patterns that must be cut, the exact saturation exponent compared with values further above it, the smallest representable fraction compared with one just below it, and the one-bit signed magnitude where the sign must be dropped for a zero result. A round trip through all sixteen unsigned 4-bit codes shows that no code is unreachable or aliased. A long run of random exponents, fractions, widths and signedness exercises the interactions of the modes against the same model.

// File: rtl/tenc_pkg.sv
package tenc_pkg;
  // Width select encoding shared by the encoder blocks.
  typedef enum logic [1:0] {
    PREC_NARROW   = 2'b00,
    PREC_MID      = 2'b01,
    PREC_WIDE     = 2'b10,
    PREC_WIDE_ALT = 2'b11
  } prec_e;
endpackage

// File: rtl/tenc_field_width.sv
module tenc_field_width #(
  parameter int CODE_W = 8,
  parameter int WW     = $clog2(CODE_W) + 1
) (
  input  logic [1:0]    prec_i,
  input  logic          signed_i,
  output logic [WW-1:0] code_w_o,
  output logic [WW-1:0] mag_w_o
);
  import tenc_pkg::*;

  localparam int NARROW_W = CODE_W / 4;
  localparam int MID_W    = CODE_W / 2;

  always_comb begin
    case (prec_e'(prec_i))
      PREC_NARROW: code_w_o = WW'(NARROW_W);
      PREC_MID:    code_w_o = WW'(MID_W);
      default:     code_w_o = WW'(CODE_W);
    endcase
    // the sign takes one bit away from the magnitude field
    mag_w_o = code_w_o - WW'(signed_i);
  end
endmodule

// File: rtl/tenc_unary_path.sv
module tenc_unary_path #(
  parameter int CODE_W = 8,
  parameter int EXP_W  = 6,
  parameter int FRAC_W = 7,
  parameter int WW     = $clog2(CODE_W) + 1
) (
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [FRAC_W-1:0]       frac_i,
  input  logic [WW-1:0]           mag_w_i,
  output logic [CODE_W-1:0]       mag_o
);
  int e_v;
  int m_v;
  int keep_v;
  logic [CODE_W-1:0] field_v;
  logic [CODE_W-1:0] run_v;

  always_comb begin
    e_v     = int'(exp_i);
    m_v     = int'(mag_w_i);
    field_v = ~({CODE_W{1'b1}} << m_v);
    run_v   = '0;
    keep_v  = 0;
    if (e_v < 0) begin
      mag_o = '0;
    end else if (e_v >= m_v - 1) begin
      // exponent run fills the whole field: clamp to the top value
      mag_o = field_v;
    end else begin
      run_v  = field_v ^ (field_v >> (e_v + 1));
      keep_v = m_v - e_v - 2;
      mag_o  = run_v | CODE_W'(frac_i >> (FRAC_W - keep_v));
    end
    // R6
    mag_in_field_chk: assert ((mag_o & ~field_v) == '0);
  end
endmodule

// File: rtl/tenc_frac_path.sv
module tenc_frac_path #(
  parameter int CODE_W = 8,
  parameter int EXP_W  = 6,
  parameter int FRAC_W = 7,
  parameter int WW     = $clog2(CODE_W) + 1
) (
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [FRAC_W-1:0]       frac_i,
  input  logic [WW-1:0]           mag_w_i,
  output logic [CODE_W-1:0]       mag_o
);
  int e_v;
  int pos_v;

  always_comb begin
    e_v   = int'(exp_i);
    // bit position of the implied one within an (M-1)-bit fraction
    pos_v = e_v + int'(mag_w_i) - 1;
    if (e_v >= 0 || pos_v < 0) begin
      mag_o = '0;
    end else begin
      mag_o = CODE_W'({1'b1, frac_i} >> (FRAC_W - pos_v));
    end
  end
endmodule

// File: rtl/tapered_encoder.sv
module tapered_encoder #(
  parameter int CODE_W = 8,
  parameter int EXP_W  = 6,
  parameter int FRAC_W = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic                    in_zero,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [FRAC_W-1:0]       in_frac,
  input  logic [1:0]              in_prec,
  input  logic                    in_signed,
  output logic                    out_valid,
  output logic [CODE_W-1:0]       out_code
);
  import tenc_pkg::*;

  localparam int WW = $clog2(CODE_W) + 1;

  logic [WW-1:0]     code_w;
  logic [WW-1:0]     mag_w;
  logic [CODE_W-1:0] unary_mag;
  logic [CODE_W-1:0] frac_mag;
  logic [CODE_W-1:0] mag_sel;
  logic [CODE_W-1:0] code_d;
  logic              sign_on;

  tenc_field_width #(.CODE_W(CODE_W), .WW(WW)) width_i (
    .prec_i   (in_prec),
    .signed_i (in_signed),
    .code_w_o (code_w),
    .mag_w_o  (mag_w)
  );

  tenc_unary_path #(.CODE_W(CODE_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .WW(WW)) unary_i (
    .exp_i   (in_exp),
    .frac_i  (in_frac),
    .mag_w_i (mag_w),
    .mag_o   (unary_mag)
  );

  tenc_frac_path #(.CODE_W(CODE_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .WW(WW)) frac_i (
    .exp_i   (in_exp),
    .frac_i  (in_frac),
    .mag_w_i (mag_w),
    .mag_o   (frac_mag)
  );

  always_comb begin
    // the two paths are mutually exclusive on the exponent sign
    mag_sel = in_zero ? '0 : (in_exp < 0 ? frac_mag : unary_mag);
    sign_on = in_signed & in_sign & (|mag_sel);
    code_d  = mag_sel | (CODE_W'(sign_on) << (code_w - WW'(1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_code <= code_d;
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_code));
  // R1
  zero_code_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_zero |=> out_code == '0);
  // R6
  narrow_clear_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_prec == PREC_NARROW |=> out_code[CODE_W-1:CODE_W/4] == '0);
  // R4
  wide_sat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_zero && !in_signed && in_prec == PREC_WIDE &&
    in_exp >= $signed(EXP_W'(CODE_W - 1)) |=> &out_code);
endmodule

// File: tb/tapered_encoder_tb_top.sv
module tapered_encoder_tb_top;
  localparam int CODE_W = 8;
  localparam int EXP_W  = 6;
  localparam int FRAC_W = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                    rst;
  logic                    in_valid;
  logic                    in_sign;
  logic                    in_zero;
  logic signed [EXP_W-1:0] in_exp;
  logic [FRAC_W-1:0]       in_frac;
  logic [1:0]              in_prec;
  logic                    in_signed;
  logic                    out_valid;
  logic [CODE_W-1:0]       out_code;

  tapered_encoder #(.CODE_W(CODE_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
    .in_zero(in_zero), .in_exp(in_exp), .in_frac(in_frac),
    .in_prec(in_prec), .in_signed(in_signed),
    .out_valid(out_valid), .out_code(out_code)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [CODE_W-1:0] exp_q[$];
  string             tag_q[$];

  task automatic check(string tag, logic [CODE_W-1:0] act, logic [CODE_W-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // value of magnitude code m in an mw-bit field, per R2/R3/R4
  function automatic real dec(int m, int mw);
    int r = 0;
    int b = mw - 1;
    int k;
    int x;
    if (m == 0) return 0.0;
    if (((m >> (mw - 1)) & 1) == 0) return real'(m) / (2.0 ** (mw - 1));
    while (b >= 0) begin
      if (((m >> b) & 1) == 0) break;
      r++;
      b--;
    end
    if (r == mw) return 2.0 ** (mw - 1);
    k = mw - r - 1;
    x = m & ((1 << k) - 1);
    return (2.0 ** (r - 1)) * (1.0 + real'(x) / (2.0 ** k));
  endfunction

  function automatic int width_of(int p);
    return (p == 0) ? CODE_W / 4 : (p == 1) ? CODE_W / 2 : CODE_W;
  endfunction

  // R5: largest code whose value does not exceed the input
  function automatic logic [CODE_W-1:0] model(int e, int f, bit z, bit s, int p, bit sg);
    int n = width_of(p);
    int mw = n - int'(sg);
    int best = 0;
    real v;
    if (z) return '0;
    v = (1.0 + real'(f) / (2.0 ** FRAC_W)) * (2.0 ** e);
    for (int m = 0; m < (1 << mw); m++) if (dec(m, mw) <= v) best = m;
    if (sg && s && best != 0) best = best | (1 << (n - 1));
    return CODE_W'(best);
  endfunction

  function automatic string tag_of(int e, bit z, int p, bit sg);
    int mw = width_of(p) - int'(sg);
    string t;
    if (z) t = "R1";
    else if (e < 0) t = "R3/R5";
    else if (e >= mw - 1) t = "R4";
    else t = "R2/R5";
    if (p == 0) t = {t, " R6"};
    if (sg) t = {t, " R7"};
    return t;
  endfunction

  task automatic push(logic [CODE_W-1:0] code, string t);
    exp_q.push_back(code);
    tag_q.push_back(t);
  endtask

  task automatic apply(int e, int f, bit z, bit s, int p, bit sg);
    @(negedge clk);
    in_valid  = 1'b1;
    in_exp    = EXP_W'(e);
    in_frac   = FRAC_W'(f);
    in_zero   = z;
    in_sign   = s;
    in_prec   = 2'(p);
    in_signed = sg;
  endtask

  task automatic drive(int e, int f, bit z, bit s, int p, bit sg);
    apply(e, f, z, s, p, sg);
    push(model(e, f, z, s, p, sg), tag_of(e, z, p, sg));
  endtask

  // monitor: pops one expected item per valid output (R8)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (exp_q.size() == 0) begin
          n_chk++;
          n_bad++;
          $display("FAIL R8: unexpected output actual %h expected none", out_code);
        end else begin
          check(tag_q.pop_front(), out_code, exp_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_sign = 1'b0; in_zero = 1'b0;
    in_exp = '0; in_frac = '0; in_prec = 2'b10; in_signed = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 valid", CODE_W'(out_valid), '0);
    check("R10 code", out_code, '0);
    rst = 1'b0;

    // R2: 8-bit, e=1, fraction 1010100 -> 11 0 10101
    apply(1, 7'b1010100, 0, 0, 2, 0); push(8'hD5, "R2 direct");
    drive(0, 0, 0, 0, 2, 0);
    drive(0, 127, 0, 0, 2, 0);
    drive(5, 127, 0, 0, 2, 0);
    // R4: exact saturation point and beyond
    apply(7, 0, 0, 0, 2, 0); push(8'hFF, "R4 direct");
    drive(20, 55, 0, 0, 2, 0);
    drive(3, 9, 0, 0, 1, 0);
    drive(2, 127, 0, 0, 1, 0);
    // R3: half, smallest step, just below it
    apply(-1, 0, 0, 0, 2, 0); push(8'h40, "R3 direct");
    drive(-7, 0, 0, 0, 2, 0);
    drive(-8, 127, 0, 0, 2, 0);
    drive(-2, 100, 0, 0, 1, 0);
    // R1 with sign in signed mode
    drive(3, 33, 1, 1, 2, 1);
    drive(-4, 3, 1, 1, 0, 0);
    // R7: signed widths, sign dropped on zero magnitude
    drive(1, 64, 0, 1, 1, 1);
    apply(0, 0, 0, 1, 0, 1); push(8'h03, "R7 direct");
    apply(-1, 127, 0, 1, 0, 1); push(8'h00, "R7 zero-sign");
    drive(1, 64, 0, 1, 2, 0);
    // R6: select 11 behaves as 8 bits
    drive(2, 77, 0, 0, 3, 0);
    drive(1, 77, 0, 0, 0, 0);

    // R11: round trip of every unsigned 4-bit code
    for (int m = 0; m < 16; m++) begin
      real v;
      int e;
      int f;
      v = dec(m, 4);
      e = 0;
      if (m == 0) begin
        apply(0, 0, 1, 0, 1, 0);
      end else begin
        while (v >= 2.0) begin v = v / 2.0; e++; end
        while (v < 1.0) begin v = v * 2.0; e--; end
        f = int'((v - 1.0) * (2.0 ** FRAC_W));
        apply(e, f, 0, 0, 1, 0);
      end
      push(CODE_W'(m), "R11");
    end

    for (int i = 0; i < 600; i++) begin
      drive(int'($urandom_range(0, 24)) - 12, int'($urandom_range(0, 127)),
            ($urandom_range(0, 19) == 0), 1'($urandom), int'($urandom_range(0, 3)),
            1'($urandom));
    end

    // R9: hold after the last item while inputs change
    apply(1, 0, 0, 0, 2, 0); push(8'hC0, "R2 last");
    @(negedge clk);
    in_valid = 1'b0; in_exp = 6'sd3; in_frac = 7'h55; in_zero = 1'b1;
    @(negedge clk);
    check("R9 hold", out_code, 8'hC0);
    check("R8 idle", CODE_W'(out_valid), '0);
    @(negedge clk);
    check("R9 hold2", out_code, 8'hC0);
    check("R8 drained", CODE_W'(exp_q.size()), '0);
    finish_run();
  end
endmodule